// File: doc/BRIEF.md
# Audio Master, Bit and Frame Clock Divider

This block turns a fast system clock into the three clocks an audio serial port and its codec need: a master clock for the codec, a bit clock, and a frame (left/right) clock. The master clock toggles once every `HALF_DIV` system cycles. The bit and frame clocks are derived from the master clock. The ratio between them is chosen by a 3-bit descending multiplier code plus a base-rate bit. Together these pick a master-clock-to-frame-rate ratio from either the power-of-two-times-32 family or the power-of-two-times-48 family. A separate select sets the number of bit clocks per frame to 32 or 48.

The master clock runs whenever `run_en` is high and `clk_hold` is low, even when no stream is active, so that a codec can lock before any data moves. Bit and frame clocks run only while `stream_en` is asserted. Starting and stopping the stream, and changes of the ratio settings, take effect only on frame boundaries, so no shortened clock pulse is ever produced. Any setting that cannot be divided evenly is rejected. In that case the block drives all three clocks low and raises an error flag.

Top module: `aud_clkdiv_top`

## Requirements
- R1: With `ratio_base48`=0, multiplier codes 4, 3, 2, 1, 0 give 32, 64, 128, 256, 512 master-clock periods per frame-clock period.
- R2: With `ratio_base48`=1, multiplier codes 3, 2, 1, 0 give 48, 96, 192, 384 master-clock periods per frame-clock period.
- R3: Each frame-clock period holds 32 bit-clock periods when `frame_48`=0 and 48 when `frame_48`=1.
- R4: The following settings are illegal: multiplier codes 5 to 7; code 4 with `ratio_base48`=1; and `frame_48`=1 with `ratio_base48`=0. An illegal setting raises `cfg_err_o` and holds `mclk_o`, `bclk_o` and `fclk_o` low. A legal setting clears `cfg_err_o` again.
- R5: With `run_en`=1, `clk_hold`=0 and `stream_en`=0, the master clock runs while `bclk_o` and `fclk_o` stay low.
- R6: When `run_en` is 0 or `clk_hold` is 1 at a clock edge, all three clock outputs are low after that edge.
- R7: The frame clock is low in the first half of each frame and high in the second half. Every frame-clock edge coincides with a falling edge of the bit clock.
- R8: A ratio change made in the middle of a frame takes effect only at the next frame boundary. The frame in progress completes with the old ratio.
- R9: When `stream_en` drops, the bit and frame clocks stop only at the end of the current frame. The master clock keeps running.
- R10: Each master-clock half period lasts `HALF_DIV` system clock cycles (default 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Run bit; enables the dividers |
| clk_hold | input | 1 | Clock gate; 1 holds all outputs low |
| stream_en | input | 1 | Requests bit and frame clocks |
| ratio_mult | input | 3 | Descending multiplier code |
| ratio_base48 | input | 1 | Selects the x48 ratio family |
| frame_48 | input | 1 | 48 bit clocks per frame instead of 32 |
| mclk_o | output | 1 | Codec master clock |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame clock |
| cfg_err_o | output | 1 | Illegal ratio setting in use |

## Verification
A ratio change and a frame boundary can fall in the same cycle. So can a stream stop and a frame boundary. In each case the new setting is loaded exactly on the tick that wraps the frame counters. The bench changes the ratio, or drops `stream_en`, right after the mid-frame rise of the frame clock. It then counts master-clock rising edges up to the following frame-clock fall, which must match the old ratio, and from that fall to the next rise, which must match the new ratio or show the bit clock silent. Frame-clock edges are checked against bit-clock falling edges in every legal measurement.

// File: rtl/aud_clkdiv_pkg.sv
package aud_clkdiv_pkg;
    localparam int MULT_W = 3;
    localparam int CNT_W  = 6;

    typedef struct packed {
        logic              base48;
        logic [MULT_W-1:0] mult;
        logic              wide;
    } aclk_cfg_t;
endpackage

// File: rtl/aud_ratio_dec.sv
module aud_ratio_dec
    import aud_clkdiv_pkg::*;
(
    input  aclk_cfg_t          cfg_i,
    output logic [CNT_W-1:0]   half_per_bit_o,
    output logic [CNT_W-1:0]   bits_per_frame_o,
    output logic               illegal_o
);
    // half_per_bit = master-clock half periods per bit = 2*ratio / bits_per_frame
    always_comb begin
        illegal_o        = 1'b0;
        half_per_bit_o   = CNT_W'(2);
        bits_per_frame_o = cfg_i.wide ? CNT_W'(48) : CNT_W'(32);
        if (!cfg_i.base48) begin
            if (cfg_i.mult > 3'd4 || cfg_i.wide) begin
                illegal_o = 1'b1;
            end else begin
                half_per_bit_o = CNT_W'(2) << (3'd4 - cfg_i.mult);
            end
        end else begin
            if (cfg_i.mult > 3'd3) begin
                illegal_o = 1'b1;
            end else if (cfg_i.wide) begin
                half_per_bit_o = CNT_W'(2) << (3'd3 - cfg_i.mult);
            end else begin
                half_per_bit_o = CNT_W'(3) << (3'd3 - cfg_i.mult);
            end
        end
    end
endmodule

// File: rtl/aud_mclk_gen.sv
module aud_mclk_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o,
    output logic mclk_o
);
    localparam int PRE_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
        logic             mclk;
    } mgen_t;

    mgen_t st_q, st_d;

    assign tick_o = en_i && (st_q.cnt == PRE_W'(HALF_DIV - 1));
    assign mclk_o = st_q.mclk;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d = '0;
        end else if (tick_o) begin
            st_d.cnt  = '0;
            st_d.mclk = ~st_q.mclk;
        end else begin
            st_d.cnt = st_q.cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/aud_frame_seq.sv
module aud_frame_seq
    import aud_clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             stream_en_i,
    input  logic [CNT_W-1:0] half_per_bit_i,
    input  logic [CNT_W-1:0] bits_per_frame_i,
    output logic             bclk_o,
    output logic             fclk_o,
    output logic             streaming_o,
    output logic             frame_end_o
);
    typedef struct packed {
        logic             strm;
        logic [CNT_W-1:0] ph;
        logic [CNT_W-1:0] bitc;
        logic             bclk;
        logic             fclk;
    } fseq_t;

    fseq_t st_q, st_d;

    logic bit_wrap;
    assign bit_wrap    = (st_q.ph == half_per_bit_i - CNT_W'(1));
    assign frame_end_o = tick_i && st_q.strm && bit_wrap
                         && (st_q.bitc == bits_per_frame_i - CNT_W'(1));
    assign bclk_o      = st_q.bclk;
    assign fclk_o      = st_q.fclk;
    assign streaming_o = st_q.strm;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d = '0;
        end else if (tick_i) begin
            if (!st_q.strm) begin
                st_d.strm = stream_en_i;
                st_d.ph   = '0;
                st_d.bitc = '0;
            end else if (bit_wrap) begin
                st_d.ph = '0;
                if (frame_end_o) begin
                    st_d.bitc = '0;
                    st_d.strm = stream_en_i;
                end else begin
                    st_d.bitc = st_q.bitc + CNT_W'(1);
                end
            end else begin
                st_d.ph = st_q.ph + CNT_W'(1);
            end
        end
        // bit clock falls at each bit start, frame clock high in second half
        st_d.bclk = st_d.strm && (st_d.ph >= (half_per_bit_i >> 1));
        st_d.fclk = st_d.strm && (st_d.bitc >= (bits_per_frame_i >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/aud_clkdiv_top.sv
module aud_clkdiv_top
    import aud_clkdiv_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              clk_hold,
    input  logic              stream_en,
    input  logic [MULT_W-1:0] ratio_mult,
    input  logic              ratio_base48,
    input  logic              frame_48,
    output logic              mclk_o,
    output logic              bclk_o,
    output logic              fclk_o,
    output logic              cfg_err_o
);
    localparam aclk_cfg_t CFG_RST = '{base48: 1'b0, mult: 3'd4, wide: 1'b0};

    aclk_cfg_t        cfg_q, cfg_d;
    logic [CNT_W-1:0] half_per_bit, bits_per_frame;
    logic             illegal, en, tick, streaming, frame_end;

    aud_ratio_dec u_dec (
        .cfg_i            (cfg_q),
        .half_per_bit_o   (half_per_bit),
        .bits_per_frame_o (bits_per_frame),
        .illegal_o        (illegal)
    );

    assign en        = run_en && !clk_hold && !illegal;
    assign cfg_err_o = illegal;

    aud_mclk_gen #(.HALF_DIV(HALF_DIV)) u_mgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en),
        .tick_o (tick),
        .mclk_o (mclk_o)
    );

    aud_frame_seq u_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .en_i             (en),
        .tick_i           (tick),
        .stream_en_i      (stream_en),
        .half_per_bit_i   (half_per_bit),
        .bits_per_frame_i (bits_per_frame),
        .bclk_o           (bclk_o),
        .fclk_o           (fclk_o),
        .streaming_o      (streaming),
        .frame_end_o      (frame_end)
    );

    // settings are accepted while idle or exactly at a frame boundary
    always_comb begin
        cfg_d = cfg_q;
        if (!streaming || frame_end) begin
            cfg_d.base48 = ratio_base48;
            cfg_d.mult   = ratio_mult;
            cfg_d.wide   = frame_48;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end
endmodule

// File: rtl/aud_clkdiv_chk.sv
module aud_clkdiv_chk (
    input logic clk,
    input logic rst_n,
    input logic run_en,
    input logic clk_hold,
    input logic mclk_o,
    input logic bclk_o,
    input logic fclk_o,
    input logic cfg_err_o
);
    p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> (!mclk_o && !bclk_o && !fclk_o));

    p_stop_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en || clk_hold) |=> (!mclk_o && !bclk_o && !fclk_o));

    p_fclk_on_bclk_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(fclk_o) && $past(run_en) && !$past(clk_hold)) |-> $fell(bclk_o));

    p_bclk_with_mclk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(bclk_o) && $past(run_en) && !$past(clk_hold)) |-> !$stable(mclk_o));
endmodule

bind aud_clkdiv_top aud_clkdiv_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .clk_hold  (clk_hold),
    .mclk_o    (mclk_o),
    .bclk_o    (bclk_o),
    .fclk_o    (fclk_o),
    .cfg_err_o (cfg_err_o)
);

// File: tb/aud_clkdiv_top_tb_top.sv
module aud_clkdiv_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       clk_hold = 1'b0;
    logic       stream_en = 1'b0;
    logic [2:0] ratio_mult = 3'd4;
    logic       ratio_base48 = 1'b0;
    logic       frame_48 = 1'b0;
    logic       mclk_o, bclk_o, fclk_o, cfg_err_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int misalign = 0;
    bit watch_align = 1'b0;
    logic pf_mon = 1'b0, pb_mon = 1'b0;

    always #5 clk = ~clk;

    aud_clkdiv_top #(.HALF_DIV(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .clk_hold(clk_hold),
        .stream_en(stream_en), .ratio_mult(ratio_mult),
        .ratio_base48(ratio_base48), .frame_48(frame_48),
        .mclk_o(mclk_o), .bclk_o(bclk_o), .fclk_o(fclk_o), .cfg_err_o(cfg_err_o)
    );

    // R7 monitor: frame-clock edges must come with a bit-clock fall
    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (watch_align && (fclk_o != pf_mon) && !(pb_mon && !bclk_o))
            misalign <= misalign + 1;
        pf_mon <= fclk_o;
        pb_mon <= bclk_o;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_edge(input logic lvl);
        logic pf;
        pf = fclk_o;
        forever begin
            @(negedge clk);
            if (fclk_o == lvl && pf != lvl) break;
            pf = fclk_o;
        end
    endtask

    task automatic count_until(input logic lvl, output int m, output int b);
        logic pf, pm, pb;
        m = 0; b = 0;
        pf = fclk_o; pm = mclk_o; pb = bclk_o;
        forever begin
            @(negedge clk);
            if (mclk_o && !pm) m++;
            if (bclk_o && !pb) b++;
            if (fclk_o == lvl && pf != lvl) break;
            pf = fclk_o; pm = mclk_o; pb = bclk_o;
        end
    endtask

    task automatic count_for(input int n, output int m, output int b, output int f);
        logic pm, pb, pf;
        m = 0; b = 0; f = 0;
        pm = mclk_o; pb = bclk_o; pf = fclk_o;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (mclk_o && !pm) m++;
            if (bclk_o && !pb) b++;
            if (fclk_o && !pf) f++;
            pm = mclk_o; pb = bclk_o; pf = fclk_o;
        end
    endtask

    task automatic setup(input logic [2:0] code, input logic b48, input logic w48,
                         input logic strm);
        @(negedge clk);
        run_en = 1'b0;
        stream_en = 1'b0;
        @(negedge clk);
        ratio_mult = code;
        ratio_base48 = b48;
        frame_48 = w48;
        run_en = 1'b1;
        stream_en = strm;
    endtask

    task automatic t_reset;
        chk("R6 reset mclk", int'(mclk_o), 0);
        chk("R6 reset bclk", int'(bclk_o), 0);
        chk("R6 reset fclk", int'(fclk_o), 0);
        chk("R4 reset cfg_err", int'(cfg_err_o), 0);
    endtask

    task automatic t_idle_mclk;
        int m, b, f;
        setup(3'd4, 1'b0, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        count_for(40, m, b, f);
        chk("R10 mclk rises in 40 cycles", m, 10);
        chk("R5 bclk idle", b, 0);
        chk("R5 fclk idle", f, 0);
    endtask

    task automatic t_frame(input string req, input logic [2:0] code, input logic b48,
                           input logic w48, input int exp_r, input int exp_b);
        int m, b;
        setup(code, b48, w48, 1'b1);
        wait_edge(1'b1);
        misalign = 0;
        watch_align = 1'b1;
        count_until(1'b1, m, b);
        watch_align = 1'b0;
        chk({req, " mclk per frame"}, m, exp_r);
        chk({"R3 bclk per frame ", req}, b, exp_b);
        chk("R7 fclk edges on bclk fall", misalign, 0);
    endtask

    task automatic t_illegal(input string tag, input logic [2:0] code, input logic b48,
                             input logic w48);
        int m, b, f;
        setup(code, b48, w48, 1'b1);
        repeat (4) @(negedge clk);
        chk({"R4 cfg_err ", tag}, int'(cfg_err_o), 1);
        count_for(30, m, b, f);
        chk({"R4 quiet clocks ", tag}, m + b + f + int'(mclk_o), 0);
    endtask

    task automatic t_recover;
        setup(3'd3, 1'b0, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        chk("R4 cfg_err cleared", int'(cfg_err_o), 0);
    endtask

    task automatic t_midframe_change;
        int m, b;
        setup(3'd4, 1'b0, 1'b0, 1'b1);
        wait_edge(1'b1);
        wait_edge(1'b1);
        ratio_mult = 3'd3;
        misalign = 0;
        watch_align = 1'b1;
        count_until(1'b0, m, b);
        chk("R8 old ratio holds to boundary", m, 16);
        count_until(1'b1, m, b);
        watch_align = 1'b0;
        chk("R8 new ratio after boundary", m, 32);
        chk("R7 fclk edges on bclk fall across change", misalign, 0);
    endtask

    task automatic t_stop;
        int m, b, f;
        setup(3'd4, 1'b0, 1'b0, 1'b1);
        wait_edge(1'b1);
        stream_en = 1'b0;
        count_until(1'b0, m, b);
        chk("R9 frame completes mclk", m, 16);
        chk("R9 frame completes bclk", b, 16);
        count_for(100, m, b, f);
        chk("R9 bclk silent after stop", b + f, 0);
        chk("R9 mclk keeps running", m, 25);
    endtask

    task automatic t_run_drop;
        setup(3'd4, 1'b0, 1'b0, 1'b1);
        wait_edge(1'b1);
        repeat (3) @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        chk("R6 run low clears clocks", int'(mclk_o) + int'(bclk_o) + int'(fclk_o), 0);
        setup(3'd4, 1'b0, 1'b0, 1'b1);
        wait_edge(1'b1);
        repeat (3) @(negedge clk);
        clk_hold = 1'b1;
        @(negedge clk);
        chk("R6 hold clears clocks", int'(mclk_o) + int'(bclk_o) + int'(fclk_o), 0);
        repeat (5) @(negedge clk);
        chk("R6 hold keeps clocks low", int'(mclk_o) + int'(bclk_o) + int'(fclk_o), 0);
        clk_hold = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_mclk();
        t_frame("R1 x32",  3'd4, 1'b0, 1'b0, 32, 32);
        t_frame("R1 x128", 3'd2, 1'b0, 1'b0, 128, 32);
        t_frame("R1 x512", 3'd0, 1'b0, 1'b0, 512, 32);
        t_frame("R2 x48",  3'd3, 1'b1, 1'b0, 48, 32);
        t_frame("R2 x192", 3'd1, 1'b1, 1'b0, 192, 32);
        t_frame("R2 x384", 3'd0, 1'b1, 1'b1, 384, 48);
        t_frame("R2 x48 wide", 3'd3, 1'b1, 1'b1, 48, 48);
        t_illegal("code4 base48", 3'd4, 1'b1, 1'b0);
        t_illegal("code5", 3'd5, 1'b0, 1'b0);
        t_illegal("x32 family wide", 3'd2, 1'b0, 1'b1);
        t_recover();
        t_midframe_change();
        t_stop();
        t_run_drop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles >= 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule